// File: doc/BRIEF.md
# Distinct Active PC Counter

This block follows thread divergence inside one SIMD core. It remembers the program counter each hardware thread last moved to. It also keeps a small content-addressed table that pairs each live PC value with the number of threads that sit at it. The scheduler sends an update whenever a group of lanes moves to a new PC. The update names up to `LANES` thread IDs, each with its own enable bit, and one target PC.

The block handles an update in three phases. In the release phase, each enabled lane takes its thread off the table entry for the PC that thread held before. In the apply phase, each enabled lane puts its thread on the entry for the new PC and records that PC for the thread. In the last phase, the number of live table entries is added to a running total and to a histogram indexed by that number. Each phase walks the lanes one at a time, so every update takes the same number of cycles. The histogram can be read at any time through a combinational index port. The thread IDs inside one update are expected to be distinct.

Top module: `dpc_counter`

## Requirements
- R1: After reset, every thread's recorded PC is 0. The distinct count, the running total, every histogram bin and the overflow flag are all 0, and `busy` is low.
- R2: An update is taken only when `upd_valid` is high while `busy` is low. From the next cycle, `busy` stays high for exactly 2*LANES+1 cycles. An `upd_valid` pulse that arrives while `busy` is high is ignored and changes no output.
- R3: Lane k is active when bit k of `upd_lane_en` is set, and its thread ID is `upd_tids[k*TID_W +: TID_W]`. A lane whose enable bit is clear takes part in neither the release phase nor the apply phase.
- R4: Release takes one from the table count of each active thread's recorded PC. An entry whose count falls to zero is freed, and this lowers `distinct_cnt`.
- R5: A recorded PC of 0 marks a thread that was never assigned. Release walks the lanes from lane 0 upward and stops at the first active lane whose recorded PC is 0. No later lane of that update is released.
- R6: Apply adds one to the entry for `upd_pc`, or creates that entry with a count of one if it does not exist. It records `upd_pc` as the PC of each active thread.
- R7: If apply needs a new entry while all ENTRIES slots are in use, the block sets the sticky `overflow` flag and creates no entry, but it still records the thread's PC. A later release of that thread finds no entry and changes no count.
- R8: When an update finishes, `acc_total` grows by the final `distinct_cnt`, and histogram bin `distinct_cnt` grows by one. While `busy` is low, neither `acc_total` nor `distinct_cnt` changes.
- R9: `hist_cnt` shows bin `hist_idx` in the same cycle. An index above ENTRIES reads as 0.
- R10: An entry that is freed by the release phase of an update can be used by the apply phase of the same update. This holds even when the table was full before the update, and in that case `overflow` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Update request |
| upd_lane_en | input | LANES | Per-lane enable |
| upd_tids | input | LANES*TID_W | Packed thread IDs, lane 0 in the low bits |
| upd_pc | input | PC_W | New PC for the active lanes |
| busy | output | 1 | An update is in progress |
| distinct_cnt | output | DCNT_W | Number of live table entries |
| acc_total | output | ACC_W | Running sum of distinct counts, one term per update |
| overflow | output | 1 | Sticky flag: the table was full when apply needed a new entry |
| hist_idx | input | DCNT_W | Histogram bin select |
| hist_cnt | output | HIST_W | Selected histogram bin |

## Verification
Within one update, the release of an old PC and the allocation of a new one share the table. The sharpest case is a full table, where the only free slot comes from an entry that the same update's release phase has just emptied.

The bench builds this case by filling every slot. It then moves the only holder of one PC to a PC the table has never seen. The bench expects the same number of distinct entries afterward and no overflow. A second step then asks for a new entry with no release to make room, and there the bench expects `overflow` to rise.

A reference model in the bench, with a map of counts and a per-thread PC array, is compared with the outputs on every idle cycle. This covers the release-stop rule, lanes that are turned off, and pulses sent while the block is busy.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REL  = 2'd1,
      ST_APP  = 2'd2,
      ST_ACC  = 2'd3
   } dpc_state_e;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_DEC  = 2'd1,
      OP_INC  = 2'd2
   } dpc_op_e;

endpackage

// File: rtl/dpc_thread_file.sv
module dpc_thread_file #(
   parameter int NUM_THREADS = 16,
   parameter int PC_W        = 16,
   parameter int TID_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TID_W-1:0] rd_tid,
   output logic [PC_W-1:0]  rd_pc,
   input  logic             wr_en,
   input  logic [TID_W-1:0] wr_tid,
   input  logic [PC_W-1:0]  wr_pc
);

   logic [PC_W-1:0] slot_pc [NUM_THREADS];

   // One register per hardware thread, cleared to the "never assigned" value
   for (genvar g = 0; g < NUM_THREADS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_pc[g] <= '0;
         end else if (wr_en && (wr_tid == TID_W'(g))) begin
            slot_pc[g] <= wr_pc;
         end
      end
   end

   always_comb begin
      rd_pc = '0;
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (rd_tid == TID_W'(i)) rd_pc = slot_pc[i];
      end
   end

endmodule

// File: rtl/dpc_pc_table.sv
module dpc_pc_table
   import dpc_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int PC_W    = 16,
   parameter int CNT_W   = 5,
   parameter int DCNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dpc_op_e           op,
   input  logic [PC_W-1:0]   key,
   output logic [DCNT_W-1:0] live,
   output logic              ovf_pulse
);

   logic [ENTRIES-1:0] vld;
   logic [ENTRIES-1:0] hit;
   logic [ENTRIES-1:0] free_oh;
   logic               hit_any;
   logic               free_any;

   assign hit_any  = |hit;
   assign free_any = ~&vld;
   // lowest unused slot as a one-hot vector
   assign free_oh  = ~vld & (vld + ENTRIES'(1));

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic             v_q;
      logic [PC_W-1:0]  k_q;
      logic [CNT_W-1:0] c_q;

      assign vld[g] = v_q;
      assign hit[g] = v_q && (k_q == key);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            k_q <= '0;
            c_q <= '0;
         end else begin
            case (op)
               OP_DEC: begin
                  if (hit[g]) begin
                     c_q <= c_q - CNT_W'(1);
                     if (c_q == CNT_W'(1)) v_q <= 1'b0;
                  end
               end
               OP_INC: begin
                  if (hit[g]) begin
                     c_q <= c_q + CNT_W'(1);
                  end else if (!hit_any && free_oh[g]) begin
                     v_q <= 1'b1;
                     k_q <= key;
                     c_q <= CNT_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      live = '0;
      for (int i = 0; i < ENTRIES; i++) live = live + DCNT_W'(vld[i]);
   end

   assign ovf_pulse = (op == OP_INC) && !hit_any && !free_any;

endmodule

// File: rtl/dpc_stats.sv
module dpc_stats #(
   parameter int ENTRIES = 4,
   parameter int DCNT_W  = 3,
   parameter int ACC_W   = 32,
   parameter int HIST_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [DCNT_W-1:0] distinct,
   output logic [ACC_W-1:0]  acc,
   input  logic [DCNT_W-1:0] rd_idx,
   output logic [HIST_W-1:0] rd_cnt
);

   logic [HIST_W-1:0] bin_q [ENTRIES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (tick) acc <= acc + ACC_W'(distinct);
   end

   for (genvar b = 0; b <= ENTRIES; b++) begin : g_bin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bin_q[b] <= '0;
         end else if (tick && (distinct == DCNT_W'(b))) begin
            bin_q[b] <= bin_q[b] + HIST_W'(1);
         end
      end
   end

   always_comb begin
      rd_cnt = '0;
      for (int i = 0; i <= ENTRIES; i++) begin
         if (rd_idx == DCNT_W'(i)) rd_cnt = bin_q[i];
      end
   end

endmodule

// File: rtl/dpc_counter.sv
module dpc_counter
   import dpc_pkg::*;
#(
   parameter int NUM_THREADS = 16,
   parameter int LANES       = 4,
   parameter int PC_W        = 16,
   parameter int ENTRIES     = 4,
   parameter int ACC_W       = 32,
   parameter int HIST_W      = 16,
   localparam int TID_W      = $clog2(NUM_THREADS),
   localparam int DCNT_W     = $clog2(ENTRIES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   upd_valid,
   input  logic [LANES-1:0]       upd_lane_en,
   input  logic [LANES*TID_W-1:0] upd_tids,
   input  logic [PC_W-1:0]        upd_pc,
   output logic                   busy,
   output logic [DCNT_W-1:0]      distinct_cnt,
   output logic [ACC_W-1:0]       acc_total,
   output logic                   overflow,
   input  logic [DCNT_W-1:0]      hist_idx,
   output logic [HIST_W-1:0]      hist_cnt
);

   localparam int CNT_W  = $clog2(NUM_THREADS + 1);
   localparam int LANE_W = $clog2(LANES);

   if (NUM_THREADS < 2) begin : g_chk_thr
      $error("dpc_counter: NUM_THREADS must be at least 2");
   end
   if (LANES < 2 || LANES > NUM_THREADS) begin : g_chk_lanes
      $error("dpc_counter: LANES must lie in 2..NUM_THREADS");
   end
   if (ENTRIES < 1) begin : g_chk_ent
      $error("dpc_counter: ENTRIES must be at least 1");
   end
   if (PC_W < 2 || ACC_W < DCNT_W || HIST_W < 1) begin : g_chk_w
      $error("dpc_counter: width parameters out of range");
   end

   dpc_state_e             state_q;
   logic [LANE_W-1:0]      lane_q;
   logic [LANES-1:0]       en_q;
   logic [LANES*TID_W-1:0] tids_q;
   logic [PC_W-1:0]        pc_q;
   logic                   stop_q;
   logic                   ovf_q;

   logic [TID_W-1:0]       cur_tid;
   logic                   cur_en;
   logic                   last_lane;
   logic [PC_W-1:0]        old_pc;
   dpc_op_e                tbl_op;
   logic [PC_W-1:0]        tbl_key;
   logic                   tf_wr;
   logic                   stat_tick;
   logic                   ovf_pulse;

   assign cur_tid   = tids_q[lane_q*TID_W +: TID_W];
   assign cur_en    = en_q[lane_q];
   assign last_lane = (lane_q == LANE_W'(LANES - 1));

   // Decode the current lane into a table operation and a thread write
   always_comb begin
      tbl_op    = OP_NONE;
      tbl_key   = pc_q;
      tf_wr     = 1'b0;
      stat_tick = 1'b0;
      case (state_q)
         ST_REL: begin
            if (cur_en && !stop_q && (old_pc != '0)) begin
               tbl_op  = OP_DEC;
               tbl_key = old_pc;
            end
         end
         ST_APP: begin
            if (cur_en) begin
               tbl_op = OP_INC;
               tf_wr  = 1'b1;
            end
         end
         ST_ACC:  stat_tick = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lane_q  <= '0;
         en_q    <= '0;
         tids_q  <= '0;
         pc_q    <= '0;
         stop_q  <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         ovf_q <= ovf_q | ovf_pulse;
         case (state_q)
            ST_IDLE: begin
               if (upd_valid) begin
                  en_q    <= upd_lane_en;
                  tids_q  <= upd_tids;
                  pc_q    <= upd_pc;
                  lane_q  <= '0;
                  stop_q  <= 1'b0;
                  state_q <= ST_REL;
               end
            end
            ST_REL: begin
               if (cur_en && !stop_q && (old_pc == '0)) stop_q <= 1'b1;
               if (last_lane) begin
                  lane_q  <= '0;
                  state_q <= ST_APP;
               end else begin
                  lane_q <= lane_q + LANE_W'(1);
               end
            end
            ST_APP: begin
               if (last_lane) begin
                  lane_q  <= '0;
                  state_q <= ST_ACC;
               end else begin
                  lane_q <= lane_q + LANE_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   dpc_thread_file #(
      .NUM_THREADS (NUM_THREADS),
      .PC_W        (PC_W),
      .TID_W       (TID_W)
   ) u_threads (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_tid (cur_tid),
      .rd_pc  (old_pc),
      .wr_en  (tf_wr),
      .wr_tid (cur_tid),
      .wr_pc  (pc_q)
   );

   dpc_pc_table #(
      .ENTRIES (ENTRIES),
      .PC_W    (PC_W),
      .CNT_W   (CNT_W),
      .DCNT_W  (DCNT_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (tbl_op),
      .key       (tbl_key),
      .live      (distinct_cnt),
      .ovf_pulse (ovf_pulse)
   );

   dpc_stats #(
      .ENTRIES (ENTRIES),
      .DCNT_W  (DCNT_W),
      .ACC_W   (ACC_W),
      .HIST_W  (HIST_W)
   ) u_stats (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (stat_tick),
      .distinct (distinct_cnt),
      .acc      (acc_total),
      .rd_idx   (hist_idx),
      .rd_cnt   (hist_cnt)
   );

   assign busy     = (state_q != ST_IDLE);
   assign overflow = ovf_q;

endmodule

// File: rtl/dpc_counter_chk.sv
module dpc_counter_chk #(
   parameter int LANES    = 4,
   parameter int ENTRIES  = 4,
   parameter int ACC_W    = 32,
   localparam int DCNT_W  = $clog2(ENTRIES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_valid,
   input logic              busy,
   input logic [DCNT_W-1:0] distinct_cnt,
   input logic [ACC_W-1:0]  acc_total,
   input logic              overflow
);

   int unsigned busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
      else           busy_len <= 0;
   end

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && upd_valid) |=> busy);                                        // R2
   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == 2*LANES + 1));                           // R2
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);                                               // R7
   AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(acc_total));                                        // R8
   AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (acc_total == $past(acc_total) + ACC_W'(distinct_cnt))); // R8
   AST_DISTINCT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(distinct_cnt));                                     // R8

endmodule

bind dpc_counter dpc_counter_chk #(
   .LANES   (LANES),
   .ENTRIES (ENTRIES),
   .ACC_W   (ACC_W)
) u_chk (.*);

// File: tb/dpc_counter_tb.sv
`timescale 1ns/1ps
module dpc_counter_tb;

   localparam int NUM_THREADS = 16;
   localparam int LANES       = 4;
   localparam int PC_W        = 16;
   localparam int ENTRIES     = 4;
   localparam int ACC_W       = 32;
   localparam int HIST_W      = 16;
   localparam int TID_W       = 4;
   localparam int DCNT_W      = 3;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   upd_valid = 1'b0;
   logic [LANES-1:0]       upd_lane_en = '0;
   logic [LANES*TID_W-1:0] upd_tids = '0;
   logic [PC_W-1:0]        upd_pc = '0;
   logic                   busy;
   logic [DCNT_W-1:0]      distinct_cnt;
   logic [ACC_W-1:0]       acc_total;
   logic                   overflow;
   logic [DCNT_W-1:0]      hist_idx = '0;
   logic [HIST_W-1:0]      hist_cnt;

   always #2 clk = ~clk;

   dpc_counter #(
      .NUM_THREADS (NUM_THREADS),
      .LANES       (LANES),
      .PC_W        (PC_W),
      .ENTRIES     (ENTRIES),
      .ACC_W       (ACC_W),
      .HIST_W      (HIST_W)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .upd_valid    (upd_valid),
      .upd_lane_en  (upd_lane_en),
      .upd_tids     (upd_tids),
      .upd_pc       (upd_pc),
      .busy         (busy),
      .distinct_cnt (distinct_cnt),
      .acc_total    (acc_total),
      .overflow     (overflow),
      .hist_idx     (hist_idx),
      .hist_cnt     (hist_cnt)
   );

   // reference model state
   int          m_tpc [NUM_THREADS];
   int          m_cnt [int];
   longint      m_acc;
   int          m_hist [ENTRIES+1];
   bit          m_ovf;
   int          busy_left;
   int          n_chk = 0;
   int          n_err = 0;
   string       cur_req = "R1";
   bit          live_cmp = 1'b0;

   task automatic chk(string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   task automatic model_update();
      int t;
      int p;
      for (int k = 0; k < LANES; k++) begin
         if (upd_lane_en[k]) begin
            t = int'(upd_tids[k*TID_W +: TID_W]);
            p = m_tpc[t];
            if (p == 0) break;
            if (m_cnt.exists(p)) begin
               m_cnt[p] = m_cnt[p] - 1;
               if (m_cnt[p] == 0) m_cnt.delete(p);
            end
         end
      end
      for (int k = 0; k < LANES; k++) begin
         if (upd_lane_en[k]) begin
            t = int'(upd_tids[k*TID_W +: TID_W]);
            p = int'(upd_pc);
            if (m_cnt.exists(p))           m_cnt[p] = m_cnt[p] + 1;
            else if (m_cnt.num() < ENTRIES) m_cnt[p] = 1;
            else                            m_ovf = 1'b1;
            m_tpc[t] = p;
         end
      end
      m_acc = m_acc + m_cnt.num();
      m_hist[m_cnt.num()] = m_hist[m_cnt.num()] + 1;
   endtask

   // model advances on the same edge as the design
   always @(posedge clk) begin
      if (!rst_n) begin
         busy_left = 0;
      end else begin
         hist_idx <= hist_idx + DCNT_W'(1);
         if (busy_left > 0)  busy_left = busy_left - 1;
         else if (upd_valid) begin
            model_update();
            busy_left = 2*LANES + 1;
         end
      end
   end

   // comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && live_cmp) begin
         chk("busy", longint'(busy), longint'(busy_left > 0));
         if (busy_left == 0) begin
            chk("distinct_cnt", longint'(distinct_cnt), longint'(m_cnt.num()));
            chk("acc_total", longint'(acc_total), m_acc & 64'hFFFF_FFFF);
            chk("overflow", longint'(overflow), longint'(m_ovf));
            chk("hist_cnt", longint'(hist_cnt),
                (int'(hist_idx) <= ENTRIES) ? longint'(m_hist[hist_idx]) : 0);
         end
      end
   end

   task automatic upd(input logic [3:0] en, input int t0, input int t1,
                      input int t2, input int t3, input int pc);
      @(negedge clk);
      upd_lane_en = en;
      upd_tids    = {TID_W'(t3), TID_W'(t2), TID_W'(t1), TID_W'(t0)};
      upd_pc      = PC_W'(pc);
      upd_valid   = 1'b1;
      @(negedge clk);
      upd_valid   = 1'b0;
      repeat (2*LANES + 2) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < NUM_THREADS; i++) m_tpc[i] = 0;
      for (int i = 0; i <= ENTRIES; i++) m_hist[i] = 0;
      m_acc = 0;
      m_ovf = 1'b0;
      busy_left = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("reset busy", longint'(busy), 0);
      chk("reset distinct", longint'(distinct_cnt), 0);
      chk("reset acc", longint'(acc_total), 0);
      chk("reset overflow", longint'(overflow), 0);
      live_cmp = 1'b1;
      repeat (10) @(negedge clk);   // hist bins walk past under R1

      cur_req = "R6";
      upd(4'b1111, 0, 1, 2, 3, 'h100);
      chk("R6 one pc", longint'(distinct_cnt), 1);

      cur_req = "R4";
      upd(4'b1111, 0, 1, 8, 9, 'h200);
      upd(4'b1111, 2, 3, 10, 11, 'h200);
      chk("R4 entry freed", longint'(distinct_cnt), 1);

      cur_req = "R3";
      upd(4'b0101, 0, 1, 2, 3, 'h300);
      chk("R3 masked lanes", longint'(distinct_cnt), 2);

      cur_req = "R5";
      upd(4'b1111, 5, 1, 3, 0, 'h400);
      chk("R5 release stop", longint'(distinct_cnt), 3);

      cur_req = "R10";
      upd(4'b0001, 6, 0, 0, 0, 'h500);
      chk("R10 table full", longint'(distinct_cnt), 4);
      upd(4'b0001, 6, 0, 0, 0, 'h600);
      chk("R10 reuse distinct", longint'(distinct_cnt), 4);
      chk("R10 no overflow", longint'(overflow), 0);

      cur_req = "R7";
      upd(4'b0001, 7, 0, 0, 0, 'h700);
      chk("R7 overflow set", longint'(overflow), 1);
      chk("R7 no new entry", longint'(distinct_cnt), 4);
      upd(4'b0001, 7, 0, 0, 0, 'h200);
      chk("R7 sticky", longint'(overflow), 1);

      cur_req = "R2";
      @(negedge clk);
      upd_lane_en = 4'b1111;
      upd_tids    = {TID_W'(15), TID_W'(14), TID_W'(13), TID_W'(12)};
      upd_pc      = PC_W'('h800);
      upd_valid   = 1'b1;
      @(negedge clk);
      upd_lane_en = 4'b1111;
      upd_tids    = {TID_W'(4), TID_W'(6), TID_W'(7), TID_W'(0)};
      upd_pc      = PC_W'('h900);
      repeat (3) @(negedge clk);     // pulses while busy are ignored
      upd_valid   = 1'b0;
      repeat (2*LANES + 2) @(negedge clk);

      cur_req = "R8";
      begin
         logic [15:0] lf = 16'hACE1;
         for (int n = 0; n < 40; n++) begin
            int b;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            b = int'(lf[3:0]);
            upd(lf[7:4], b, (b+3)%16, (b+6)%16, (b+9)%16,
                (int'(lf[10:8]) % 6 + 1) * 'h10);
         end
      end

      cur_req = "R9";
      repeat (16) @(negedge clk);
      finish_run();
   end

endmodule